// File: doc/BRIEF.md
# Panel power sequencer

This block drives the supply-enable and backlight-enable lines of a flat panel in a fixed order with programmed waits. Software sets or clears a target bit in a key-protected control register. The block then runs the power-up sequence: supply on, a wait, a second wait, then the backlight. When the target bit is cleared it runs the power-down sequence: backlight off, a wait, supply off, a second wait. After that, a lockout window must pass before the panel may be powered again. A request made during power-down or during the lockout is kept, and it starts power-up as soon as the lockout ends.

The waits are counted on strobes from an internal prescaler. The fine strobe has a period of 100 µs and the coarse strobe a period of 100 ms. The prescaler restarts on every phase change, so each phase has an exact length in clock cycles. A fine-unit phase of N units lasts N·CLKS_PER_FINE+1 cycles. A lockout of M coarse units lasts M·CLKS_PER_FINE·FINE_PER_COARSE+1 cycles. Software can read progress from a status register. If a panel-reset input arrives while power-down-on-reset is enabled, the target bit is cleared and the panel powers down.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset all delay registers hold their default values. On-delay reads 0x083401F4 (2100 and 500 units), off-delay reads 0x138801F4 (5000 and 500 units) and cycle-delay reads 7. Control and status read 0, and both enables are low.
- R2: Register addresses are control 0, status 1, on-delay 2, off-delay 3 and cycle-delay 4.
  - On-delay: port select in bits 31:30, power-up wait in bits 28:16 and backlight wait in bits 12:0.
  - Off-delay: power-down wait in bits 28:16 and backlight-off wait in bits 12:0.
  - Cycle-delay: the field in bits 4:0.
  - Unused bits read 0, so writing all ones to on-delay reads back 0xDFFF1FFF.
- R3: Control bits are target 0, power-down-on-reset 1, backlight request 2 and supply override 3. A control write takes effect only when bits 31:16 equal 0xABCD; any other key leaves the register and the outputs unchanged.
- R4: When target is set in the idle state with no lockout, the supply turns on in the next cycle. The panel reports enabled and the backlight turns on after (up·C+1)+(bl·C+1) cycles, where C is CLKS_PER_FINE.
- R5: The backlight output is high only in the powered-on state while the backlight request bit is set. Toggling that bit there changes the output one cycle after the write.
- R6: When target is cleared in the powered-on state, the backlight drops in the next cycle. The supply drops blo·C+1 cycles later, and the power-down wait of dn·C+1 cycles follows.
- R7: If the cycle field F is greater than 1, the lockout lasts (F−1)·C·FINE_PER_COARSE+1 cycles after the power-down wait. During that time status bit 27 is set and the supply stays off.
- R8: If target is set again during power-down or during the lockout, the request waits. Power-up begins one cycle after the lockout ends.
- R9: A cycle field of 0 or 1 means no lockout: the block goes idle straight after the power-down wait.
- R10: While power-down-on-reset is set, a high panel-reset input clears the target bit and so starts power-down. With that bit clear, panel-reset has no effect.
- R11: The override bit turns the supply on only in the idle state outside the lockout. In the power-down and lockout phases it has no effect.
- R12: Status reads bit 31 for enabled (powered-on state), bits 29:28 for progress (00 idle, 01 up, 10 down) and bit 27 for lockout active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| panel_reset | input | 1 | Panel reset request, acts if power-down-on-reset is set |
| vdd_en | output | 1 | Panel supply enable |
| bl_en | output | 1 | Backlight enable |

## Verification
Two things can fall in the same cycle: a new power-up request and the power-down in progress, including its lockout. The bench clears target and, three cycles into the backlight-off wait, writes target, backlight and override back on. The scoreboard then requires the remaining down phases and the lockout to run with their exact cycle gaps and the supply kept off. It expects the supply to come back through the override in the cycle the lockout ends, and power-up to start one cycle later. A second collision comes from a panel-reset pulse while the panel is on. The target clear must win, and the down sequence must skip the lockout when the cycle field is 1.

// File: rtl/pps_pkg.sv
// Shared constants, types and reset timings of the panel power sequencer.
package pps_pkg;
    localparam int DLY_W = 13;
    localparam int CYC_W = 5;
    localparam logic [15:0] UNLOCK_KEY = 16'hABCD;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_ON   = 3'd2;
    localparam logic [2:0] A_OFF  = 3'd3;
    localparam logic [2:0] A_CYC  = 3'd4;

    typedef enum logic [2:0] {
        S_OFF, S_UP_VDD, S_UP_BL, S_ON, S_DN_BL, S_DN_VDD, S_LOCK
    } seq_state_t;

    typedef struct packed {
        logic vdd_ovr;
        logic bl_req;
        logic pdor;
        logic tgt;
    } ctrl_t;

    typedef struct packed {
        logic [DLY_W-1:0] up_vdd;
        logic [DLY_W-1:0] up_bl;
        logic [DLY_W-1:0] dn_vdd;
        logic [DLY_W-1:0] dn_bl;
        logic [CYC_W-1:0] cyc_field;
    } timing_t;

    function automatic int ceil_div(input int n, input int d);
        return (n + d - 1) / d;
    endfunction

    // reset timings, converted from microseconds into register units
    localparam int DEF_UP_VDD = ceil_div(210000, 100);
    localparam int DEF_UP_BL  = ceil_div(50000, 100);
    localparam int DEF_DN_VDD = ceil_div(500000, 100);
    localparam int DEF_DN_BL  = ceil_div(50000, 100);
    localparam int DEF_CYC    = ceil_div(510000, 100000) + 1;
endpackage

// File: rtl/pps_tick_gen.sv
// Prescaler: one-cycle fine strobe every CLKS_PER_FINE clocks and a coarse
// strobe every FINE_PER_COARSE fine strobes. Assumes both parameters >= 1.
// A restart pulse realigns both counters so a new phase starts on a full period.
module pps_tick_gen #(
    parameter int CLKS_PER_FINE   = 100,
    parameter int FINE_PER_COARSE = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic fine_tick,
    output logic coarse_tick
);
    localparam int FW = (CLKS_PER_FINE > 1) ? $clog2(CLKS_PER_FINE) : 1;
    localparam int CW = (FINE_PER_COARSE > 1) ? $clog2(FINE_PER_COARSE) : 1;

    logic [FW-1:0] fine_cnt;
    logic [CW-1:0] coarse_cnt;

    assign fine_tick   = (fine_cnt == FW'(CLKS_PER_FINE - 1));
    assign coarse_tick = fine_tick && (coarse_cnt == CW'(FINE_PER_COARSE - 1));

    // advance the two divider counters, realigning on restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            fine_cnt   <= '0;
            coarse_cnt <= '0;
        end else if (fine_tick) begin
            fine_cnt   <= '0;
            coarse_cnt <= coarse_tick ? '0 : coarse_cnt + 1'b1;
        end else begin
            fine_cnt <= fine_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pps_regs.sv
// Register file: key-protected control, read-only status, two delay registers
// and the cycle-delay field. Read data is combinational on the address.
// Assumes the status word is assembled by the caller.
module pps_regs
    import pps_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    input  logic        panel_reset,
    input  logic [31:0] status_word,
    output ctrl_t       ctrl_q,
    output timing_t     tim_q,
    output logic [31:0] rdata
);
    logic [1:0] port_sel_q;
    logic       clr_tgt;
    logic       unused_wbits;

    assign clr_tgt      = panel_reset && ctrl_q.pdor;
    assign unused_wbits = ^{wdata[15:13]};

    // register writes, key check on control, reset-driven target clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q          <= '0;
            port_sel_q      <= '0;
            tim_q.up_vdd    <= DLY_W'(DEF_UP_VDD);
            tim_q.up_bl     <= DLY_W'(DEF_UP_BL);
            tim_q.dn_vdd    <= DLY_W'(DEF_DN_VDD);
            tim_q.dn_bl     <= DLY_W'(DEF_DN_BL);
            tim_q.cyc_field <= CYC_W'(DEF_CYC);
        end else begin
            if (wr_en) begin
                case (addr)
                    A_CTRL: if (wdata[31:16] == UNLOCK_KEY) ctrl_q <= ctrl_t'(wdata[3:0]);
                    A_ON: begin
                        port_sel_q   <= wdata[31:30];
                        tim_q.up_vdd <= wdata[28:16];
                        tim_q.up_bl  <= wdata[12:0];
                    end
                    A_OFF: begin
                        tim_q.dn_vdd <= wdata[28:16];
                        tim_q.dn_bl  <= wdata[12:0];
                    end
                    A_CYC:   tim_q.cyc_field <= wdata[4:0];
                    default: ;
                endcase
            end
            if (clr_tgt) ctrl_q.tgt <= 1'b0;
        end
    end

    // read multiplexer
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {28'd0, ctrl_q};
            A_STAT:  rdata = status_word;
            A_ON:    rdata = {port_sel_q, 1'b0, tim_q.up_vdd, 3'd0, tim_q.up_bl};
            A_OFF:   rdata = {3'd0, tim_q.dn_vdd, 3'd0, tim_q.dn_bl};
            A_CYC:   rdata = {27'd0, tim_q.cyc_field};
            default: rdata = '0;
        endcase
    end

    a_r3_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && wdata[31:16] != UNLOCK_KEY && !clr_tgt) |=> $stable(ctrl_q));

    a_r10_reset_clears_target: assert property (@(posedge clk) disable iff (!rst_n)
        (panel_reset && ctrl_q.pdor) |=> !ctrl_q.tgt);
endmodule

// File: rtl/pps_seq_fsm.sv
// Sequencing state machine with one shared down-counter. The counter is loaded
// on each phase change and counts fine strobes, or coarse strobes in the lockout.
// Assumes the prescaler restarts whenever restart is high.
module pps_seq_fsm
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       target,
    input  timing_t    tim,
    input  logic       fine_tick,
    input  logic       coarse_tick,
    output seq_state_t state,
    output logic       restart,
    output logic       vdd_on,
    output logic       bl_window
);
    seq_state_t       st_d;
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W-1:0] load_val;
    logic [CYC_W-1:0] lock_units;
    logic             dec;

    assign lock_units = (tim.cyc_field > CYC_W'(1)) ? tim.cyc_field - 1'b1 : '0;

    // next-state decision
    always_comb begin
        st_d = state;
        case (state)
            S_OFF:    if (target) st_d = S_UP_VDD;
            S_UP_VDD: if (!target) st_d = S_DN_BL; else if (cnt_q == '0) st_d = S_UP_BL;
            S_UP_BL:  if (!target) st_d = S_DN_BL; else if (cnt_q == '0) st_d = S_ON;
            S_ON:     if (!target) st_d = S_DN_BL;
            S_DN_BL:  if (cnt_q == '0) st_d = S_DN_VDD;
            S_DN_VDD: if (cnt_q == '0) st_d = (lock_units == '0) ? S_OFF : S_LOCK;
            S_LOCK:   if (cnt_q == '0) st_d = S_OFF;
            default:  st_d = S_OFF;
        endcase
    end

    // phase length loaded when entering a phase
    always_comb begin
        case (st_d)
            S_UP_VDD: load_val = tim.up_vdd;
            S_UP_BL:  load_val = tim.up_bl;
            S_DN_BL:  load_val = tim.dn_bl;
            S_DN_VDD: load_val = tim.dn_vdd;
            S_LOCK:   load_val = DLY_W'(lock_units);
            default:  load_val = '0;
        endcase
    end

    assign restart = (st_d != state);
    assign dec     = (cnt_q != '0) && ((state == S_LOCK) ? coarse_tick : fine_tick);

    // state and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_OFF;
            cnt_q <= '0;
        end else begin
            state <= st_d;
            if (restart)  cnt_q <= load_val;
            else if (dec) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign vdd_on    = (state == S_UP_VDD) || (state == S_UP_BL) ||
                       (state == S_ON)     || (state == S_DN_BL);
    assign bl_window = (state == S_ON);

    a_r8_up_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_UP_VDD && $past(state) != S_UP_VDD) |-> $past(state) == S_OFF);

    a_r4_on_after_bl_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == S_ON) |-> $past(state) == S_UP_BL);

    a_r6_supply_after_bl: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DN_VDD && $past(state) != S_DN_VDD) |-> $past(state) == S_DN_BL);
endmodule

// File: rtl/panel_pwr_seq.sv
// Top of the panel power sequencer: prescaler, register file and sequencer,
// plus the output gating of supply override and backlight request.
// Assumes a single clock domain; panel_reset is synchronous to clk.
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int CLKS_PER_FINE   = 100,
    parameter int FINE_PER_COARSE = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        panel_reset,
    output logic        vdd_en,
    output logic        bl_en
);
    ctrl_t       ctrl;
    timing_t     tim;
    seq_state_t  state;
    logic        restart, fine_tick, coarse_tick, fsm_vdd, bl_window;
    logic        lock_active;
    logic [1:0]  progress;
    logic [31:0] status_word;

    pps_tick_gen #(.CLKS_PER_FINE(CLKS_PER_FINE), .FINE_PER_COARSE(FINE_PER_COARSE)) tick_i (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .fine_tick(fine_tick), .coarse_tick(coarse_tick));

    pps_regs regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .panel_reset(panel_reset), .status_word(status_word),
        .ctrl_q(ctrl), .tim_q(tim), .rdata(reg_rdata));

    pps_seq_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .target(ctrl.tgt), .tim(tim),
        .fine_tick(fine_tick), .coarse_tick(coarse_tick), .state(state),
        .restart(restart), .vdd_on(fsm_vdd), .bl_window(bl_window));

    // status word assembly
    always_comb begin
        case (state)
            S_UP_VDD, S_UP_BL:  progress = 2'b01;
            S_DN_BL, S_DN_VDD:  progress = 2'b10;
            default:            progress = 2'b00;
        endcase
    end
    assign lock_active = (state == S_LOCK);
    assign status_word = {(state == S_ON), 1'b0, progress, lock_active, 27'd0};

    assign vdd_en = fsm_vdd || (ctrl.vdd_ovr && state == S_OFF);
    assign bl_en  = bl_window && ctrl.bl_req;

    a_r7_no_supply_in_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |-> !vdd_en);

    a_r5_backlight_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        bl_en |-> vdd_en);

    a_r11_override_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        (vdd_en && !fsm_vdd) |-> (progress == 2'b00 && !lock_active));
endmodule

// File: tb/panel_pwr_seq_tb_top.sv
// Scoreboard bench: each test queues the output events it expects, with cycle
// gaps, and a negedge monitor pops and compares them as they appear.
module panel_pwr_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPF = 4;
    localparam int FPC = 5;
    localparam logic [2:0] AD_CTRL = 3'd0, AD_STAT = 3'd1, AD_ON = 3'd2, AD_OFF = 3'd3, AD_CYC = 3'd4;
    localparam logic [31:0] KEY = 32'hABCD_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = AD_STAT;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        panel_reset = 1'b0;
    logic        vdd_en, bl_en;

    panel_pwr_seq #(.CLKS_PER_FINE(CPF), .FINE_PER_COARSE(FPC)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .panel_reset(panel_reset),
        .vdd_en(vdd_en), .bl_en(bl_en));

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [5:0] obs;
        int         gap;
        string      tag;
    } ev_t;

    ev_t        sb_q[$];
    int         n_checks = 0;
    int         n_fail = 0;
    int         cyc = 0;
    int         last_cyc = 0;
    logic [5:0] last_obs = '0;
    logic [5:0] mon_obs;
    logic [31:0] rd;

    always @(posedge clk) cyc <= cyc + 1;

    // obs = {enabled, progress[1:0], lockout, vdd_en, bl_en}
    function automatic logic [5:0] mk(input logic en, input logic [1:0] pg,
                                      input logic lk, input logic v, input logic b);
        return {en, pg, lk, v, b};
    endfunction

    task automatic expect_ev(input logic [5:0] o, input int gap, input string tag);
        ev_t e;
        e.obs = o; e.gap = gap; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp_v);
        end
    endtask

    // monitor: compare each observed change of the status/enable vector
    always @(negedge clk) begin
        if (rst_n && reg_addr == AD_STAT) begin
            mon_obs = {reg_rdata[31], reg_rdata[29:28], reg_rdata[27], vdd_en, bl_en};
            if (mon_obs !== last_obs) begin
                if (sb_q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL unexpected event: actual %b expected no change", mon_obs);
                end else begin
                    ev_t e;
                    e = sb_q.pop_front();
                    chk({e.tag, " event"}, 32'(mon_obs), 32'(e.obs));
                    if (e.gap >= 0) chk({e.tag, " gap"}, 32'(cyc - last_cyc), 32'(e.gap));
                end
                last_obs = mon_obs;
                last_cyc = cyc;
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; reg_addr = AD_STAT;
    endtask

    task automatic rdreg(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; #1;
        d = reg_rdata;
        reg_addr = AD_STAT;
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
        repeat (5) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam int G_UP  = (3*CPF + 1) + (2*CPF + 1);
    localparam int G_BLO = 2*CPF + 1;
    localparam int G_DN  = 4*CPF + 1;
    localparam int G_LK  = 2*CPF*FPC + 1;

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        rdreg(AD_ON, rd);   chk("R1 on-delay", rd, {3'b000, 13'(210000/100), 3'b000, 13'(50000/100)});
        rdreg(AD_OFF, rd);  chk("R1 off-delay", rd, {3'b000, 13'(500000/100), 3'b000, 13'(50000/100)});
        rdreg(AD_CYC, rd);  chk("R1 cycle", rd, 32'd7);
        rdreg(AD_CTRL, rd); chk("R1 control", rd, 32'd0);
        rdreg(AD_STAT, rd); chk("R1 status", rd, 32'd0);
        chk("R1 enables", {30'd0, vdd_en, bl_en}, 32'd0);

        // R2: field layout and unused bits
        wr(AD_ON, 32'hFFFF_FFFF);  rdreg(AD_ON, rd);  chk("R2 on all-ones", rd, 32'hDFFF_1FFF);
        wr(AD_OFF, 32'hFFFF_FFFF); rdreg(AD_OFF, rd); chk("R2 off all-ones", rd, 32'h1FFF_1FFF);
        wr(AD_CYC, 32'hFFFF_FFFF); rdreg(AD_CYC, rd); chk("R2 cycle all-ones", rd, 32'h0000_001F);
        wr(AD_ON, 32'h4003_0002);  rdreg(AD_ON, rd);  chk("R2 on program", rd, 32'h4003_0002);
        wr(AD_OFF, 32'h0004_0002);
        wr(AD_CYC, 32'd3);

        // R3: wrong key ignored
        wr(AD_CTRL, 32'h1234_000F);
        repeat (10) @(posedge clk);
        rdreg(AD_CTRL, rd); chk("R3 bad key control", rd, 32'd0);
        chk("R3 bad key supply", {31'd0, vdd_en}, 32'd0);

        // R4: power-up with backlight request; R12 status while rising
        expect_ev(mk(0, 2'b01, 0, 1, 0), -1, "R4 supply on");
        expect_ev(mk(1, 2'b00, 0, 1, 1), G_UP, "R4 enabled+backlight");
        wr(AD_CTRL, KEY | 32'h5);
        @(posedge clk);
        rdreg(AD_STAT, rd); chk("R12 status up", rd, 32'h1000_0000);
        drain();
        rdreg(AD_STAT, rd); chk("R12 status on", rd, 32'h8000_0000);

        // R5: backlight request toggled while on
        expect_ev(mk(1, 2'b00, 0, 1, 0), -1, "R5 backlight off");
        wr(AD_CTRL, KEY | 32'h1);
        drain();
        expect_ev(mk(1, 2'b00, 0, 1, 1), -1, "R5 backlight on");
        wr(AD_CTRL, KEY | 32'h5);
        drain();

        // R10: panel reset without power-down-on-reset has no effect
        @(posedge clk); #1 panel_reset = 1'b1;
        repeat (3) @(posedge clk); #1 panel_reset = 1'b0;
        repeat (10) @(posedge clk);
        chk("R10 no-pdor supply", {31'd0, vdd_en}, 32'd1);
        rdreg(AD_CTRL, rd); chk("R10 no-pdor control", rd, 32'h5);

        // R6/R7/R8/R11: power-down with re-request and override during it
        expect_ev(mk(0, 2'b10, 0, 1, 0), -1, "R6 backlight first");
        expect_ev(mk(0, 2'b10, 0, 0, 0), G_BLO, "R6 supply off (R11 override ignored)");
        expect_ev(mk(0, 2'b00, 1, 0, 0), G_DN, "R7 lockout start");
        expect_ev(mk(0, 2'b00, 0, 1, 0), G_LK, "R7 lockout end, R11 override in idle");
        expect_ev(mk(0, 2'b01, 0, 1, 0), 1, "R8 held request starts");
        expect_ev(mk(1, 2'b00, 0, 1, 1), G_UP, "R8 back on");
        wr(AD_CTRL, KEY | 32'h4);
        repeat (2) @(posedge clk);
        rdreg(AD_STAT, rd); chk("R12 status down", rd, 32'h2000_0000);
        wr(AD_CTRL, KEY | 32'hD);
        drain();

        // R10/R9: panel reset with pdor, cycle field 1 -> no lockout
        wr(AD_CYC, 32'd1);
        wr(AD_CTRL, KEY | 32'h7);
        expect_ev(mk(0, 2'b10, 0, 1, 0), -1, "R10 reset power-down");
        expect_ev(mk(0, 2'b10, 0, 0, 0), G_BLO, "R10 supply off");
        expect_ev(mk(0, 2'b00, 0, 0, 0), G_DN, "R9 idle without lockout");
        @(posedge clk); #1 panel_reset = 1'b1;
        @(posedge clk); #1 panel_reset = 1'b0;
        drain();
        rdreg(AD_CTRL, rd); chk("R10 target cleared", rd, 32'h6);

        // R11: override in idle
        expect_ev(mk(0, 2'b00, 0, 1, 0), -1, "R11 override on");
        wr(AD_CTRL, KEY | 32'h8);
        drain();
        expect_ev(mk(0, 2'b00, 0, 0, 0), -1, "R11 override off");
        wr(AD_CTRL, KEY);
        drain();

        chk("scoreboard empty", 32'(sb_q.size()), 32'd0);
        finish_run();
    end
endmodule